// File: doc/BRIEF.md
# Burst-Threshold Byte FIFO Pair

This block holds the receive and transmit byte queues of a serial bus master. The shift engine pushes received bytes into the receive queue and pulls bytes to send from the transmit queue. Software empties and fills the two queues one byte at a time, through a byte-wide read port and a byte-wide write port.

Software does not poll full and empty flags. Each direction instead raises one of two requests. A ready request means a whole burst of threshold+1 bytes can be moved. A drain request covers the tail of a transfer, when the transfer engine's count of remaining bytes has fallen below one burst. A 16-bit status word gives the queue size code and both fill counts, so that software knows how many bytes to move on a drain. A 16-bit configuration word sets the two thresholds.

A soft clear empties both queues at the end of a transfer and keeps the thresholds.

Top module: `burst_fifo_pair`

## Requirements
- R1: Each queue holds 8 << DEPTH_CODE bytes. DEPTH_CODE appears in status[15:14].
- R2: A write with cfg_we loads the receive threshold from cfg_wdata[5:0] and the transmit threshold from cfg_wdata[13:8]. The burst of each direction is its threshold + 1. After rst_n both thresholds are half the capacity.
- R3: Bytes pushed with rx_push come out on rd_data in arrival order. rd_data shows the oldest byte, and rd_en removes it at the clock edge. status[6:0] holds the receive fill count.
- R4: While the receive queue is empty, rd_data reads 0, and rd_en leaves the count and the order unchanged.
- R5: Bytes written with wr_en come out on tx_pdata in order. tx_pdata reads 0 while the transmit queue is empty. tx_pop removes the oldest byte. status[13:7] holds the transmit fill count.
- R6: A write to a full transmit queue is dropped. It sets tx_ovf at the same edge, and tx_ovf stays set until a soft clear or a reset.
- R7: rx_ready is 1 when the receive drain window is closed and the receive count is at least the receive burst. The receive drain window is open when remaining is nonzero and below the receive burst.
- R8: rx_drain is 1 when the receive drain window is open and the receive queue is not empty.
- R9: tx_ready is 1 when the transmit drain window is closed and the free space is at least the transmit burst. The transmit drain window is open when remaining is nonzero and below the transmit burst.
- R10: tx_drain is 1 when the transmit drain window is open and the transmit count is below remaining.
- R11: soft_rst empties both queues, zeroes both counts and clears tx_ovf at the next edge. It keeps both thresholds.
- R12: A push from the engine into a full receive queue is dropped, and the queue contents stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of both queues |
| cfg_we | input | 1 | Threshold configuration write |
| cfg_wdata | input | 16 | Configuration word |
| rx_push | input | 1 | Engine pushes a received byte |
| rx_pdata | input | 8 | Received byte |
| rd_en | input | 1 | Software reads one byte |
| rd_data | output | 8 | Oldest receive byte (0 when empty) |
| wr_en | input | 1 | Software writes one byte |
| wr_data | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Engine takes one byte |
| tx_pdata | output | 8 | Oldest transmit byte (0 when empty) |
| remaining | input | 16 | Bytes left in the current transfer |
| status | output | 16 | {code, tx count, rx count} |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_ready | output | 1 | Receive burst request |
| rx_drain | output | 1 | Receive tail request |
| tx_ready | output | 1 | Transmit burst request |
| tx_drain | output | 1 | Transmit tail request |

## Verification
The fill counts, the oldest-byte outputs and tx_ovf change one rising edge after the push, pop, write, clear or configuration that caused them. The four requests follow the registered counts, and they also follow the remaining input within the same cycle, through logic only. The bench drives its inputs after a falling edge and updates its queue model just after the next rising edge. It compares every output at the following falling edge. So each result is checked in the first cycle it is due, and the bench never samples it as it changes.

// File: rtl/burst_fifo_pkg.sv
// Shared constants for the burst-threshold FIFO pair.
// Assumes: the depth code is at most 3, so capacity is at most 64 bytes.
package burst_fifo_pkg;
    localparam int BYTE_W = 8;
    localparam int THR_W  = 6;
    localparam int REM_W  = 16;
    localparam int STAT_W = 16;
    localparam int CNTF_W = 7;   // width of each fill-count status field
endpackage

// File: rtl/byte_fifo.sv
// Circular byte queue with a registered fill count.
// It drops a push when full and ignores a pop when empty, and shows 0 as head when empty.
// Assumes: CAP is a power of two, so the pointers wrap by themselves.
module byte_fifo #(
    parameter int CAP = 8,
    parameter int W   = 8,
    localparam int PW = $clog2(CAP),
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  pdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          drop
);
    logic [W-1:0]  mem [CAP];
    logic [PW-1:0] wptr, rptr;
    logic          do_push, do_pop, empty;

    // Accept decisions are taken from the state before this edge.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CW'(CAP));
        do_push = push && !full;
        do_pop  = pop && !empty;
        drop    = push && full;
        head    = empty ? '0 : mem[rptr];
    end

    // Update the pointers and the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Write the storage; it has no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= pdata;
    end

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(CAP));
    assert_full_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> $stable(count));
    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (count == '0));
endmodule

// File: rtl/burst_req.sv
// Ready and drain request logic for one direction.
// IS_TX selects the variant: transmit compares free space, receive compares fill.
// Assumes: cnt never exceeds CAP.
module burst_req #(
    parameter int CAP   = 8,
    parameter bit IS_TX = 1'b0,
    parameter int THR_W = 6,
    parameter int REM_W = 16,
    localparam int CW   = $clog2(CAP) + 1,
    localparam int XW   = REM_W + 1
) (
    input  logic [THR_W-1:0] thr,
    input  logic [CW-1:0]    cnt,
    input  logic [REM_W-1:0] rem,
    output logic             ready,
    output logic             drain
);
    logic [XW-1:0] burst, level, rem_x, cnt_x;
    logic          window;

    // The window opens when the transfer tail is shorter than one burst.
    always_comb begin
        burst  = XW'(thr) + 1'b1;
        rem_x  = XW'(rem);
        cnt_x  = XW'(cnt);
        window = (rem != '0) && (rem_x < burst);
    end

    generate
        if (IS_TX) begin : g_tx
            // Transmit: a burst fits in the free space; the tail still needs bytes.
            always_comb begin
                level = XW'(CAP) - cnt_x;
                ready = !window && (level >= burst);
                drain = window && (cnt_x < rem_x);
            end
        end else begin : g_rx
            // Receive: a burst is waiting; the tail has data in the queue.
            always_comb begin
                level = cnt_x;
                ready = !window && (level >= burst);
                drain = window && (cnt_x != '0);
            end
        end
    endgenerate
endmodule

// File: rtl/burst_fifo_pair.sv
// Receive and transmit byte queues with burst-ready and tail-drain requests.
// It holds the threshold configuration, the status word and the sticky overflow flag.
// Assumes: DEPTH_CODE is 0..3; the engine and software use the byte ports directly.
module burst_fifo_pair
    import burst_fifo_pkg::*;
#(
    parameter int DEPTH_CODE = 0,
    localparam int CAP = 8 << DEPTH_CODE,
    localparam int CW  = $clog2(CAP) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              cfg_we,
    input  logic [STAT_W-1:0] cfg_wdata,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_pdata,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              tx_pop,
    output logic [BYTE_W-1:0] tx_pdata,
    input  logic [REM_W-1:0]  remaining,
    output logic [STAT_W-1:0] status,
    output logic              tx_ovf,
    output logic              rx_ready,
    output logic              rx_drain,
    output logic              tx_ready,
    output logic              tx_drain
);
    logic [THR_W-1:0] rx_thr, tx_thr;
    logic [CW-1:0]    rx_cnt, tx_cnt;
    logic             rx_full, tx_full, rx_drop, tx_drop;

    // Threshold register; rst_n sets both thresholds to half the capacity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_thr <= THR_W'(CAP / 2);
            tx_thr <= THR_W'(CAP / 2);
        end else if (cfg_we) begin
            rx_thr <= cfg_wdata[THR_W-1:0];
            tx_thr <= cfg_wdata[8 +: THR_W];
        end
    end

    // Sticky overflow: set by a dropped write, cleared by a soft clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) tx_ovf <= 1'b0;
        else if (tx_drop)       tx_ovf <= 1'b1;
    end

    byte_fifo #(.CAP(CAP), .W(BYTE_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .push(rx_push), .pdata(rx_pdata), .pop(rd_en),
        .head(rd_data), .count(rx_cnt), .full(rx_full), .drop(rx_drop));

    byte_fifo #(.CAP(CAP), .W(BYTE_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .push(wr_en), .pdata(wr_data), .pop(tx_pop),
        .head(tx_pdata), .count(tx_cnt), .full(tx_full), .drop(tx_drop));

    burst_req #(.CAP(CAP), .IS_TX(1'b0), .THR_W(THR_W), .REM_W(REM_W)) u_rxreq (
        .thr(rx_thr), .cnt(rx_cnt), .rem(remaining), .ready(rx_ready), .drain(rx_drain));

    burst_req #(.CAP(CAP), .IS_TX(1'b1), .THR_W(THR_W), .REM_W(REM_W)) u_txreq (
        .thr(tx_thr), .cnt(tx_cnt), .rem(remaining), .ready(tx_ready), .drain(tx_drain));

    // Status word: size code over the transmit and receive fill counts.
    always_comb begin
        status = {2'(DEPTH_CODE), CNTF_W'(tx_cnt), CNTF_W'(rx_cnt)};
    end

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovf && !soft_rst) |=> tx_ovf);
    assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tx_full && !soft_rst) |=> tx_ovf);
    assert_soft_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (status[13:0] == '0 && !tx_ovf));
    assert_rx_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_drop && !rd_en && !soft_rst) |=> (rx_cnt == CW'(CAP)));
endmodule

// File: tb/sim_burst_fifo_pair.sv
module sim_burst_fifo_pair;
    localparam int CODE = 0;
    localparam int CAP  = 8 << CODE;

    logic clk = 0;
    logic rst_n, soft_rst, cfg_we, rx_push, rd_en, wr_en, tx_pop;
    logic [15:0] cfg_wdata, remaining;
    logic [7:0]  rx_pdata, wr_data;
    logic [7:0]  rd_data, tx_pdata;
    logic [15:0] status;
    logic tx_ovf, rx_ready, rx_drain, tx_ready, tx_drain;

    int checks = 0, fails = 0;
    byte unsigned rxq[$], txq[$];
    int m_rthr, m_tthr;
    bit m_ovf;

    always #10 clk = ~clk;

    burst_fifo_pair #(.DEPTH_CODE(CODE)) u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .rx_push(rx_push), .rx_pdata(rx_pdata), .rd_en(rd_en), .rd_data(rd_data),
        .wr_en(wr_en), .wr_data(wr_data), .tx_pop(tx_pop), .tx_pdata(tx_pdata),
        .remaining(remaining), .status(status), .tx_ovf(tx_ovf), .rx_ready(rx_ready),
        .rx_drain(rx_drain), .tx_ready(tx_ready), .tx_drain(tx_drain));

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Reference update, taken just after each rising edge from the held inputs.
    task automatic model_step();
        bit rfull, rempty, tfull, tempty;
        if (!rst_n) begin
            rxq.delete(); txq.delete(); m_ovf = 0;
            m_rthr = CAP / 2; m_tthr = CAP / 2;
            return;
        end
        if (cfg_we) begin m_rthr = cfg_wdata[5:0]; m_tthr = cfg_wdata[13:8]; end
        if (soft_rst) begin rxq.delete(); txq.delete(); m_ovf = 0; return; end
        rfull = rxq.size() == CAP; rempty = rxq.size() == 0;
        tfull = txq.size() == CAP; tempty = txq.size() == 0;
        if (rd_en && !rempty) void'(rxq.pop_front());
        if (rx_push && !rfull) rxq.push_back(rx_pdata);
        if (tx_pop && !tempty) void'(txq.pop_front());
        if (wr_en) begin
            if (tfull) m_ovf = 1; else txq.push_back(wr_data);
        end
    endtask

    // Compare every output with the reference.
    task automatic compare(string ph);
        int rc = rxq.size(), tc = txq.size(), rem = remaining;
        bit rwin = rem != 0 && rem < m_rthr + 1;
        bit twin = rem != 0 && rem < m_tthr + 1;
        chk({"R3/R4 rd_data ", ph}, rd_data, rc != 0 ? rxq[0] : 0);
        chk({"R5 tx_pdata ", ph}, tx_pdata, tc != 0 ? txq[0] : 0);
        chk({"R3 rx count ", ph}, status[6:0], rc);
        chk({"R5 tx count ", ph}, status[13:7], tc);
        chk({"R1 size code ", ph}, status[15:14], CODE);
        chk({"R6 tx_ovf ", ph}, tx_ovf, m_ovf);
        chk({"R7 rx_ready ", ph}, rx_ready, !rwin && rc >= m_rthr + 1);
        chk({"R8 rx_drain ", ph}, rx_drain, rwin && rc != 0);
        chk({"R9 tx_ready ", ph}, tx_ready, !twin && (CAP - tc) >= m_tthr + 1);
        chk({"R10 tx_drain ", ph}, tx_drain, twin && tc < rem);
    endtask

    task automatic tick(string ph);
        @(posedge clk); #1 model_step();
        @(negedge clk); compare(ph);
    endtask

    task automatic idle();
        soft_rst = 0; cfg_we = 0; rx_push = 0; rd_en = 0; wr_en = 0; tx_pop = 0;
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle(); rst_n = 0; cfg_wdata = 0; remaining = 0; rx_pdata = 0; wr_data = 0;
        tick("reset"); tick("reset");
        chk("R2 reset burst gives no rx_ready", rx_ready, 0);
        rst_n = 1;

        // R12: overfill the receive queue from the engine.
        for (int i = 0; i < CAP + 3; i++) begin
            idle(); rx_push = 1; rx_pdata = 8'(8'h30 + i); tick("R12 rx overfill");
        end
        idle(); tick("R12 rx overfill");
        chk("R12 rx count held at capacity", status[6:0], CAP);
        chk("R12 oldest byte kept", rd_data, 8'h30);
        // R4: read all bytes, then read the empty queue.
        for (int i = 0; i < CAP + 3; i++) begin
            idle(); rd_en = 1; tick("R4 drain reads");
        end
        idle(); tick("R4 empty");
        chk("R4 empty read data", rd_data, 0);

        // R6: overfill the transmit queue from software.
        for (int i = 0; i < CAP + 2; i++) begin
            idle(); wr_en = 1; wr_data = 8'(8'hA0 + i); tick("R6 tx overfill");
        end
        idle(); tick("R6 tx overfill");
        chk("R6 overflow flagged", tx_ovf, 1);

        // R11: a soft clear with thresholds kept.
        idle(); soft_rst = 1; tick("R11 soft clear");
        idle(); tick("R11 soft clear");
        chk("R11 counts cleared", status[13:0], 0);
        chk("R11 ovf cleared", tx_ovf, 0);

        // R2: new thresholds, rx 2 (burst 3), tx 1 (burst 2).
        idle(); cfg_we = 1; cfg_wdata = 16'h0102; tick("R2 cfg");
        for (int i = 0; i < 3; i++) begin
            idle(); rx_push = 1; rx_pdata = 8'(i + 1); tick("R2 cfg fill");
        end
        chk("R2 rx_ready at new burst", rx_ready, 1);
        remaining = 2; idle(); tick("R8 window");
        chk("R8 rx_drain with tail of 2", rx_drain, 1);
        remaining = 0;

        // Mixed traffic with varied rates and remaining counts.
        for (int n = 0; n < 3000; n++) begin
            idle();
            rx_push = ($urandom_range(0, 3) < (n / 500) % 4);
            rx_pdata = 8'($urandom);
            rd_en = ($urandom_range(0, 3) < ((n / 700) + 1) % 4);
            wr_en = ($urandom_range(0, 2) == 0) || (n % 900 < 100);
            wr_data = 8'($urandom);
            tx_pop = ($urandom_range(0, 2) == 0);
            if (n % 37 == 0) remaining = 16'($urandom_range(0, 9));
            if (n % 251 == 0) begin
                cfg_we = 1;
                cfg_wdata = {2'b0, 6'($urandom_range(0, CAP - 1)), 2'b0, 6'($urandom_range(0, CAP - 1))};
            end
            if (n % 613 == 612) soft_rst = 1;
            tick("mixed");
        end

        idle(); rst_n = 0; tick("reset again");
        rst_n = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule